// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block sequences an on-chip temperature converter. It keeps the converter unpowered until a temperature command arrives. It then powers the converter and runs a fixed conversion window of `CONV_CYCLES` clock cycles, which models the roughly 800 µs the converter needs. When the converter signals done, the block captures the 14-bit result into a 16-bit read-only register and drops power again without being told to. The analog sensor and the serial bus protocol are outside the block. The serial side is seen through two signals: a pulse that marks the start of a read, and a level that is high while any serial transfer is in flight.

A read that begins while a conversion is running aborts that conversion and removes converter power. The block remembers the abort and waits until the serial bus goes idle. It then restarts the conversion, with the timer cleared to zero. The register always shows the last completed result, so a host can read a stable value at any time. A sticky valid flag shows whether any result has been captured since reset.

The controller has four states:
- `ST_OFF`: powered down.
- `ST_CONV`: timed window.
- `ST_CAPT`: waiting for done.
- `ST_HOLD`: aborted, waiting for serial idle.

Its transitions are:
- start: `ST_OFF`→`ST_CONV` on a command.
- expire: `ST_CONV`→`ST_CAPT` on the last timer count.
- capture: `ST_CAPT`→`ST_OFF` on done with no read.
- abort: `ST_CONV` or `ST_CAPT`→`ST_HOLD` on a read start.
- resume: `ST_HOLD`→`ST_CONV` once the bus is idle.

A read start wins over done in the same cycle.

Top module: `tconv_seq`

## Requirements
- R1: After reset, `conv_pwr` = 0, `conv_aborted` = 0, `temp_reg` = 0 and `result_valid` = 0.
- R2: A `cmd_start` pulse sampled while powered down and not aborted sets `conv_pwr` to 1 from the next cycle.
- R3: With `conv_done` already high, `conv_pwr` stays high for exactly `CONV_CYCLES`+1 cycles: the timed window plus one capture cycle. `temp_reg` changes only on the clock edge that follows a cycle in which `conv_pwr` and `conv_done` were both high. If `conv_done` is low when the window ends, power stays on until `conv_done` rises.
- R4: A captured result appears as `temp_reg` = {2'b00, code}. Bit 13 is the sign of a 14-bit two's-complement value in units of 1/32 °C. Examples: +150 °C = 14'h12C0 and −40 °C = 14'h3B00.
- R5: After a capture, `conv_pwr` stays 0 until the next `cmd_start`.
- R6: An `rd_start` sampled while `conv_pwr` is 1 (timed window or capture cycle) clears `conv_pwr` and sets `conv_aborted` from the next cycle.
- R7: While aborted, power stays off for as long as `bus_busy` is 1. In the cycle after `bus_busy` is sampled 0, `conv_pwr` rises, `conv_aborted` clears, and a full window of `CONV_CYCLES`+1 cycles follows.
- R8: An aborted conversion leaves `temp_reg` unchanged. This holds when `rd_start` and `conv_done` fall in the same cycle.
- R9: `result_valid` becomes 1 with the first capture and then stays 1 until reset.
- R10: A `cmd_start` sampled while converting or aborted has no effect: the window length and the power state are unchanged.
- R11: An `rd_start` sampled while powered down leaves `conv_pwr` at 0 and `temp_reg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Temperature command pulse |
| rd_start | input | 1 | Pulse: a serial read begins |
| bus_busy | input | 1 | Serial transfer in progress |
| conv_done | input | 1 | Converter result ready |
| conv_code | input | CODE_W | Converter result, two's complement |
| conv_pwr | output | 1 | Converter power-up / run |
| conv_aborted | output | 1 | Conversion aborted, waiting for bus idle |
| temp_reg | output | REG_W | Last completed result, zero-padded |
| result_valid | output | 1 | A result has been captured since reset |

## Verification
A read start and the completion of a conversion can fall in the same cycle. This happens when `rd_start` is asserted in the capture cycle while `conv_done` is high. The bench provokes this by sweeping the abort point over every cycle of the window, from the first timed cycle through the capture cycle, with `conv_done` held high. For every point it checks that power drops, that the abort is recorded, and that the register still holds the previous result. It then releases the bus and checks that a full-length window follows and that the code present at the later capture is the one stored.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_CONV = 2'd1,
        ST_CAPT = 2'd2,
        ST_HOLD = 2'd3
    } tconv_state_e;
endpackage

// File: rtl/tconv_timer.sv
module tconv_timer #(
    parameter int CONV_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic last
);
    localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST_VAL)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/tconv_fsm.sv
module tconv_fsm
    import tconv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic rd_start,
    input  logic bus_busy,
    input  logic conv_done,
    input  logic tmr_last,
    output logic tmr_clr,
    output logic tmr_run,
    output logic capture,
    output logic conv_pwr,
    output logic conv_aborted
);
    tconv_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: start, expire, capture, abort, resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cmd_start) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (rd_start)      state_d = ST_HOLD;
                else if (tmr_last) state_d = ST_CAPT;
            end
            ST_CAPT: begin
                if (rd_start)       state_d = ST_HOLD;
                else if (conv_done) state_d = ST_OFF;
            end
            ST_HOLD: begin
                if (!bus_busy) state_d = ST_CONV;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        tmr_clr      = 1'b0;
        tmr_run      = 1'b0;
        capture      = 1'b0;
        conv_pwr     = 1'b0;
        conv_aborted = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                tmr_clr = 1'b1;
            end
            ST_CONV: begin
                tmr_run  = 1'b1;
                conv_pwr = 1'b1;
            end
            ST_CAPT: begin
                conv_pwr = 1'b1;
                capture  = conv_done && !rd_start;
            end
            ST_HOLD: begin
                tmr_clr      = 1'b1;
                conv_aborted = 1'b1;
            end
            default: tmr_clr = 1'b1;
        endcase
    end
endmodule

// File: rtl/tconv_result.sv
module tconv_result #(
    parameter int CODE_W = 14,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    output logic [REG_W-1:0]  temp_reg,
    output logic              result_valid
);
    localparam int PAD_W = REG_W - CODE_W;

    logic [REG_W-1:0] padded;

    generate
        if (PAD_W > 0) begin : g_pad
            assign padded = {{PAD_W{1'b0}}, code_in};
        end else begin : g_nopad
            assign padded = code_in[REG_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_reg     <= '0;
            result_valid <= 1'b0;
        end else if (capture) begin
            temp_reg     <= padded;
            result_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq #(
    parameter int CONV_CYCLES = 100000,
    parameter int CODE_W      = 14,
    parameter int REG_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              rd_start,
    input  logic              bus_busy,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    output logic              conv_pwr,
    output logic              conv_aborted,
    output logic [REG_W-1:0]  temp_reg,
    output logic              result_valid
);
    logic tmr_clr, tmr_run, tmr_last, capture;

    tconv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    tconv_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .rd_start     (rd_start),
        .bus_busy     (bus_busy),
        .conv_done    (conv_done),
        .tmr_last     (tmr_last),
        .tmr_clr      (tmr_clr),
        .tmr_run      (tmr_run),
        .capture      (capture),
        .conv_pwr     (conv_pwr),
        .conv_aborted (conv_aborted)
    );

    tconv_result #(.CODE_W(CODE_W), .REG_W(REG_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (capture),
        .code_in      (conv_code),
        .temp_reg     (temp_reg),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/tconv_seq_chk.sv
module tconv_seq_chk #(
    parameter int CODE_W = 14,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              rd_start,
    input logic              bus_busy,
    input logic              conv_done,
    input logic [CODE_W-1:0] conv_code,
    input logic              conv_pwr,
    input logic              conv_aborted,
    input logic [REG_W-1:0]  temp_reg,
    input logic              result_valid
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_pwr && !conv_aborted && cmd_start) |=> conv_pwr);

    p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_reg != $past(temp_reg)) |-> ($past(conv_pwr) && $past(conv_done) && !$past(rd_start)));

    p_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_reg != $past(temp_reg)) |-> (temp_reg[CODE_W-1:0] == $past(conv_code)
                                            && temp_reg[REG_W-1:CODE_W] == '0));

    p_stay_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_pwr && !conv_aborted && !cmd_start) |=> !conv_pwr);

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_pwr && rd_start) |=> (!conv_pwr && conv_aborted));

    p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_aborted && !bus_busy) |=> (conv_pwr && !conv_aborted));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_aborted && bus_busy) |=> (!conv_pwr && conv_aborted));

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_pwr && rd_start) |=> $stable(temp_reg));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> result_valid);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_pwr && conv_aborted));
endmodule

bind tconv_seq tconv_seq_chk #(.CODE_W(CODE_W), .REG_W(REG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .rd_start     (rd_start),
    .bus_busy     (bus_busy),
    .conv_done    (conv_done),
    .conv_code    (conv_code),
    .conv_pwr     (conv_pwr),
    .conv_aborted (conv_aborted),
    .temp_reg     (temp_reg),
    .result_valid (result_valid)
);

// File: tb/tconv_seq_bench.sv
`timescale 1ns/1ps
module tconv_seq_bench;
    localparam int CC     = 8;
    localparam int CODE_W = 14;
    localparam int REG_W  = 16;
    localparam int WD     = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic              rd_start = 1'b0;
    logic              bus_busy = 1'b0;
    logic              conv_done = 1'b1;
    logic [CODE_W-1:0] conv_code = '0;
    logic              conv_pwr;
    logic              conv_aborted;
    logic [REG_W-1:0]  temp_reg;
    logic              result_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    tconv_seq #(.CONV_CYCLES(CC), .CODE_W(CODE_W), .REG_W(REG_W)) u_tconv_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .rd_start     (rd_start),
        .bus_busy     (bus_busy),
        .conv_done    (conv_done),
        .conv_code    (conv_code),
        .conv_pwr     (conv_pwr),
        .conv_aborted (conv_aborted),
        .temp_reg     (temp_reg),
        .result_valid (result_valid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] exp_reg(input logic [CODE_W-1:0] c);
        return {{(REG_W-CODE_W){1'b0}}, c};
    endfunction

    // counts cycles with conv_pwr high, starting with the current sample
    task automatic count_pwr(output int n);
        n = 0;
        for (int i = 0; i < CC + 40; i++) begin
            if (!conv_pwr) break;
            n++;
            step();
        end
    endtask

    task automatic pulse_cmd();
        cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
    endtask

    initial begin
        logic [CODE_W-1:0] codes [8];
        logic [REG_W-1:0]  prev;
        int n;
        int v;

        codes[0] = 14'h12C0; codes[1] = 14'h3B00; codes[2] = 14'h1FFF; codes[3] = 14'h2000;
        codes[4] = 14'h0001; codes[5] = 14'h3FFF; codes[6] = 14'h0320; codes[7] = 14'h0000;

        repeat (3) step();
        // R1 reset state
        check(conv_pwr == 1'b0, "R1 pwr", int'(conv_pwr), 0);
        check(conv_aborted == 1'b0, "R1 aborted", int'(conv_aborted), 0);
        check(temp_reg == '0, "R1 temp_reg", int'(temp_reg), 0);
        check(result_valid == 1'b0, "R1 valid", int'(result_valid), 0);
        rst_n = 1'b1;
        step();

        // R11 read while powered down
        rd_start = 1'b1; bus_busy = 1'b1;
        step();
        rd_start = 1'b0;
        check(conv_pwr == 1'b0, "R11 pwr", int'(conv_pwr), 0);
        check(conv_aborted == 1'b0, "R11 aborted", int'(conv_aborted), 0);
        step();
        bus_busy = 1'b0;
        check(temp_reg == '0, "R11 temp_reg", int'(temp_reg), 0);

        // R2 R3 R4 R5 R9: plain conversions over a set of codes
        for (int k = 0; k < 8; k++) begin
            conv_code = codes[k];
            pulse_cmd();
            check(conv_pwr == 1'b1, "R2 pwr after cmd", int'(conv_pwr), 1);
            count_pwr(n);
            check(n == CC + 1, "R3 window length", n, CC + 1);
            check(temp_reg == exp_reg(codes[k]), "R4 captured value", int'(temp_reg), int'(exp_reg(codes[k])));
            check(result_valid == 1'b1, "R9 valid", int'(result_valid), 1);
            if (k == 0 || k == 1) begin
                v = temp_reg[CODE_W-1] ? int'(temp_reg[CODE_W-1:0]) - (1 << CODE_W) : int'(temp_reg[CODE_W-1:0]);
                check(v == ((k == 0) ? 150 * 32 : -40 * 32), "R4 scale", v, (k == 0) ? 4800 : -1280);
            end
            repeat (3) step();
            check(conv_pwr == 1'b0, "R5 stays off", int'(conv_pwr), 0);
        end

        // R3 late done: power holds until done rises
        conv_done = 1'b0;
        prev = temp_reg;
        conv_code = 14'h0ABC;
        pulse_cmd();
        repeat (CC + 4) step();
        check(conv_pwr == 1'b1, "R3 waits for done", int'(conv_pwr), 1);
        check(temp_reg == prev, "R3 no early capture", int'(temp_reg), int'(prev));
        conv_done = 1'b1;
        step();
        check(conv_pwr == 1'b0, "R3 off after done", int'(conv_pwr), 0);
        check(temp_reg == exp_reg(14'h0ABC), "R3 late capture", int'(temp_reg), int'(exp_reg(14'h0ABC)));

        // R10 extra command mid-conversion
        conv_code = 14'h0155;
        pulse_cmd();
        n = 1;
        repeat (2) begin step(); n++; end
        cmd_start = 1'b1;
        step(); n++;
        cmd_start = 1'b0;
        begin
            int rest;
            count_pwr(rest);
            n = n + rest - 1;
        end
        check(n == CC + 1, "R10 window unchanged", n, CC + 1);

        // R6 R7 R8 R10: abort at every cycle of the window, capture cycle included
        for (int k = 0; k <= CC; k++) begin
            logic [CODE_W-1:0] nc;
            prev = temp_reg;
            conv_code = 14'(k * 37 + 5);
            pulse_cmd();
            repeat (k) step();
            rd_start = 1'b1; bus_busy = 1'b1;
            step();
            rd_start = 1'b0;
            check(conv_pwr == 1'b0, "R6 pwr drops", int'(conv_pwr), 0);
            check(conv_aborted == 1'b1, "R6 aborted", int'(conv_aborted), 1);
            check(temp_reg == prev, "R8 temp kept", int'(temp_reg), int'(prev));
            cmd_start = 1'b1;
            step();
            cmd_start = 1'b0;
            step();
            check(conv_pwr == 1'b0, "R10 cmd ignored while aborted", int'(conv_pwr), 0);
            check(conv_aborted == 1'b1, "R7 holds while busy", int'(conv_aborted), 1);
            nc = 14'(k * 101 + 2000);
            conv_code = nc;
            bus_busy = 1'b0;
            step();
            check(conv_pwr == 1'b1, "R7 resume pwr", int'(conv_pwr), 1);
            check(conv_aborted == 1'b0, "R7 resume flag", int'(conv_aborted), 0);
            count_pwr(n);
            check(n == CC + 1, "R7 full window", n, CC + 1);
            check(temp_reg == exp_reg(nc), "R7 restart capture", int'(temp_reg), int'(exp_reg(nc)));
            check(result_valid == 1'b1, "R9 valid kept", int'(result_valid), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule